// File: doc/BRIEF.md
# Pipelined-Address Bus Cycle Sequencer

This block is the master side of a bus that runs one read or write cycle at a time. It can also start the address phase of the following cycle while the data phase of the current one is still waiting for its acknowledge. Each bus state lasts one clock. An internal requester offers an address and a cycle definition with a valid flag. The sequencer takes the request with a one-cycle pulse on `req_take` and copies it into its own address register. It then drives that address and definition on the bus, with an active-low strobe, in the state that follows the take.

Overlap is chosen by the slave. The sequencer samples the active-low next-address input once the current address has been on the bus for at least one full state. If that input is low and a request is waiting, the sequencer issues the next address at once and enters the pipelined wait state. That state repeats until the active-low ready input ends the cycle, and the following cycle starts in the short pipelined first state. If the next-address input was low but nothing is waiting, the cycle finishes in an idle-wait state instead. Any cycle that finishes without a pipelined address is followed by a normal first state or by idle. A hold request hands the bus to another master, but only at a point where no pipelined cycle is owed.

Top module: `pipe_bus_seq`

## Requirements
- R1: After reset the state output is idle, `ads_n` is 1 and `hold_ack` is 0. The state codes are: idle 0, first state 1, second state 2, pipelined first state 3, pipelined wait 4, idle-wait 5, hold 6.
- R2: From idle with `req_valid` high and no hold request, `req_take` is 1 in that cycle. The next state is the first state (1), with `ads_n` 0 and the request's address and definition on the bus. State 1 is always followed by state 2, whatever the value of `ready_n`.
- R3: The next-address input is ignored in state 1, so no request is taken there. In state 2, if `na_n` is 0, `ready_n` is 1 and `req_valid` is 1, the request is taken. The next state is 4, with `ads_n` 0 and the new address on the bus. In state 2 with `na_n` 1 and `ready_n` 1, the state stays at 2.
- R4: State 4 repeats while `ready_n` is 1. Every repeat after the first has `ads_n` 1 and keeps the address unchanged. When `ready_n` is 0 in state 4, the next state is 3.
- R5: `ready_n` is ignored in state 3. In state 3, `na_n` 0 with a request leads to state 4 (request taken). `na_n` 0 without a request leads to state 5. `na_n` 1 leads to state 2.
- R6: In state 2, `na_n` 0 with no request and `ready_n` 1 leads to state 5. In state 5 with `ready_n` 1, a request that arrives later is taken and the next state is 4.
- R7: A cycle that ends in state 2 or 5 (with `ready_n` 0) leads to state 1 if a request is valid, taking it. Otherwise it leads to idle.
- R8: When `ready_n` and `na_n` are both 0 in the same state-2 cycle, the ready input wins. The cycle ends and a valid request starts a normal cycle in state 1, not state 4.
- R9: A hold request is granted, moving to state 6 with `hold_ack` 1, only from idle or at the end of a cycle in state 2 or 5. At those points it has priority over a valid request, which is not taken. At the end of state 4 the next state is 3 even while a hold request is high.
- R10: When the hold request drops, state 6 leads to idle with `hold_ack` 0, and only after that can state 1 follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one bus state per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Internal request waiting |
| req_addr | input | AW | Address of the waiting request |
| req_def | input | DW | Cycle definition of the waiting request |
| req_take | output | 1 | Request accepted in this cycle |
| na_n | input | 1 | Next-address request, active low |
| ready_n | input | 1 | Cycle acknowledge, active low |
| hold_req | input | 1 | Another master asks for the bus |
| hold_ack | output | 1 | Bus released to the other master |
| bus_addr | output | AW | Address driven on the bus |
| bus_def | output | DW | Cycle definition driven on the bus |
| ads_n | output | 1 | Address strobe, active low, in the first state of a new address |
| bus_state | output | 3 | Current bus state code |

## Verification
The next-address sample and the ready acknowledge can both arrive in the same state-2 cycle. One directed scenario drives both low at once while a request is waiting. The bench then expects a non-pipelined start in state 1 with the new address, not a pipelined wait state. A second case of the same kind pairs a hold request with the end of a pipelined wait state. There the bench expects the pipelined first state rather than hold, and expects hold to be granted only at the next non-pipelined cycle end.

// File: rtl/pipe_bus_seq.sv
module pipe_bus_seq #(
  parameter int AW = 32,
  parameter int DW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_def,
  output logic          req_take,
  input  logic          na_n,
  input  logic          ready_n,
  input  logic          hold_req,
  output logic          hold_ack,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_def,
  output logic          ads_n,
  output logic [2:0]    bus_state
);
  localparam logic [2:0] S_IDLE = 3'd0;
  localparam logic [2:0] S_T1   = 3'd1;
  localparam logic [2:0] S_T2   = 3'd2;
  localparam logic [2:0] S_T1P  = 3'd3;
  localparam logic [2:0] S_T2P  = 3'd4;
  localparam logic [2:0] S_T2I  = 3'd5;
  localparam logic [2:0] S_HOLD = 3'd6;

  logic [2:0]    st, nxt;
  logic          take, ads_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] def_q;

  wire na  = ~na_n;
  wire rdy = ~ready_n;

  always_comb begin
    nxt  = st;
    take = 1'b0;
    case (st)
      S_IDLE: begin
        if (hold_req) nxt = S_HOLD;
        else if (req_valid) begin
          nxt  = S_T1;
          take = 1'b1;
        end
      end
      S_HOLD: if (!hold_req) nxt = S_IDLE;
      S_T1:   nxt = S_T2;
      S_T2, S_T2I: begin
        if (rdy) begin
          if (hold_req) nxt = S_HOLD;
          else if (req_valid) begin
            nxt  = S_T1;
            take = 1'b1;
          end else nxt = S_IDLE;
        end else if (na || st == S_T2I) begin
          if (req_valid) begin
            nxt  = S_T2P;
            take = 1'b1;
          end else nxt = S_T2I;
        end
      end
      S_T2P:  if (rdy) nxt = S_T1P;
      S_T1P: begin
        if (na) begin
          if (req_valid) begin
            nxt  = S_T2P;
            take = 1'b1;
          end else nxt = S_T2I;
        end else nxt = S_T2;
      end
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      ads_q  <= 1'b0;
      addr_q <= '0;
      def_q  <= '0;
    end else begin
      st    <= nxt;
      ads_q <= take;
      if (take) begin
        addr_q <= req_addr;
        def_q  <= req_def;
      end
    end
  end

  assign req_take  = take;
  assign ads_n     = ~ads_q;
  assign hold_ack  = (st == S_HOLD);
  assign bus_addr  = addr_q;
  assign bus_def   = def_q;
  assign bus_state = st;
endmodule

// File: rtl/pipe_bus_seq_chk.sv
module pipe_bus_seq_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_take,
  input logic          na_n,
  input logic          ready_n,
  input logic          hold_req,
  input logic          hold_ack,
  input logic          ads_n,
  input logic [AW-1:0] bus_addr,
  input logic [2:0]    bus_state
);
  localparam logic [2:0] S_IDLE = 3'd0;
  localparam logic [2:0] S_T1   = 3'd1;
  localparam logic [2:0] S_T2   = 3'd2;
  localparam logic [2:0] S_T1P  = 3'd3;
  localparam logic [2:0] S_T2P  = 3'd4;
  localparam logic [2:0] S_T2I  = 3'd5;
  localparam logic [2:0] S_HOLD = 3'd6;

  a_r2_t1_then_t2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_state == S_T1 |=> bus_state == S_T2);
  a_r2_strobe_states: assert property (@(posedge clk) disable iff (!rst_n)
    !ads_n |-> (bus_state == S_T1 || bus_state == S_T2P));
  a_r2_take_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    req_take |-> req_valid);
  a_r3_take_strobes: assert property (@(posedge clk) disable iff (!rst_n)
    req_take |=> !ads_n);
  a_r3_t2_waits: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_state == S_T2 && na_n && ready_n) |=> bus_state == S_T2);
  a_r4_t2p_repeat: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_state == S_T2P && ready_n) |=> (bus_state == S_T2P && ads_n && $stable(bus_addr)));
  a_r4_t2p_to_t1p: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_state == S_T2P && !ready_n) |=> bus_state == S_T1P);
  a_r5_t1p_exit: assert property (@(posedge clk) disable iff (!rst_n)
    bus_state == S_T1P |=> (bus_state == S_T2 || bus_state == S_T2I || bus_state == S_T2P));
  a_r9_idle_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_state == S_IDLE || bus_state == S_HOLD) |=>
      (bus_state == S_IDLE || bus_state == S_HOLD || bus_state == S_T1));
  a_r9_hold_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_req && bus_state == S_IDLE) |=> hold_ack);
  a_r10_no_direct_t1: assert property (@(posedge clk) disable iff (!rst_n)
    hold_ack |=> bus_state != S_T1);
endmodule

bind pipe_bus_seq pipe_bus_seq_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_take(req_take),
  .na_n(na_n), .ready_n(ready_n), .hold_req(hold_req), .hold_ack(hold_ack),
  .ads_n(ads_n), .bus_addr(bus_addr), .bus_state(bus_state)
);

// File: tb/tb_pipe_bus_seq.sv
`timescale 1ns/1ps
module tb_pipe_bus_seq;
  logic        clk = 0, rst_n = 0;
  logic        req_valid = 0, na_n = 1, ready_n = 1, hold_req = 0;
  logic [31:0] req_addr = 0;
  logic [3:0]  req_def = 0;
  logic        req_take, hold_ack, ads_n;
  logic [31:0] bus_addr;
  logic [3:0]  bus_def;
  logic [2:0]  bus_state;
  int checks = 0, errors = 0;
  bit done = 0;

  pipe_bus_seq dut (.clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_def(req_def), .req_take(req_take), .na_n(na_n), .ready_n(ready_n),
    .hold_req(hold_req), .hold_ack(hold_ack), .bus_addr(bus_addr), .bus_def(bus_def),
    .ads_n(ads_n), .bus_state(bus_state));

  always #4 clk = ~clk;

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic drive(bit v, logic [31:0] a, bit na, bit rdy, bit hold);
    req_valid = v; req_addr = a; req_def = a[3:0];
    na_n = ~na; ready_n = ~rdy; hold_req = hold;
    #1;
  endtask

  task automatic st_is(string tag, logic [2:0] s);
    chk(tag, "state", {29'd0, bus_state}, {29'd0, s});
  endtask

  task automatic test_reset();
    st_is("R1", 3'd0);
    chk("R1", "ads_n", ads_n, 1);
    chk("R1", "hold_ack", hold_ack, 0);
  endtask

  task automatic test_nonpipe();
    drive(1, 32'hA0, 0, 0, 0);
    chk("R2", "take from idle", req_take, 1);
    step(); st_is("R2", 3'd1);
    chk("R2", "ads_n in T1", ads_n, 0);
    chk("R2", "addr", bus_addr, 32'hA0);
    chk("R2", "def", bus_def, 4'h0);
    drive(0, 0, 0, 1, 0);
    step(); st_is("R2 ready ignored in T1", 3'd2);
    drive(0, 0, 0, 0, 0);
    step(); st_is("R3 T2 wait", 3'd2);
    chk("R3", "ads_n in T2", ads_n, 1);
    drive(0, 0, 0, 1, 0);
    step(); st_is("R7 end to idle", 3'd0);
  endtask

  task automatic test_pipe();
    drive(1, 32'hB1, 0, 0, 0);
    step(); st_is("R2", 3'd1);
    drive(1, 32'hB2, 1, 0, 0);
    chk("R3", "no take in T1", req_take, 0);
    step(); st_is("R3", 3'd2);
    chk("R3", "take in T2", req_take, 1);
    step(); st_is("R3 enter T2P", 3'd4);
    chk("R3", "ads_n T2P", ads_n, 0);
    chk("R3", "new addr", bus_addr, 32'hB2);
    drive(0, 0, 0, 0, 0);
    step(); st_is("R4 T2P repeat", 3'd4);
    chk("R4", "ads_n repeat", ads_n, 1);
    chk("R4", "addr held", bus_addr, 32'hB2);
    drive(0, 0, 0, 1, 0);
    step(); st_is("R4 to T1P", 3'd3);
    step(); st_is("R5 ready ignored in T1P", 3'd2);
    step(); st_is("R7", 3'd0);
    drive(0, 0, 0, 0, 0);
  endtask

  task automatic test_t1p_na();
    drive(1, 32'hC1, 0, 0, 0);
    step();
    drive(1, 32'hC2, 1, 0, 0);
    step(); step(); st_is("R3", 3'd4);
    drive(0, 0, 0, 1, 0);
    step(); st_is("R4", 3'd3);
    drive(1, 32'hC3, 1, 0, 0);
    chk("R5", "take in T1P", req_take, 1);
    step(); st_is("R5 T1P to T2P", 3'd4);
    chk("R5", "addr", bus_addr, 32'hC3);
    chk("R5", "ads_n", ads_n, 0);
    drive(0, 0, 0, 1, 0);
    step(); st_is("R4", 3'd3);
    drive(0, 0, 1, 0, 0);
    step(); st_is("R5 T1P to T2I", 3'd5);
    drive(1, 32'hC4, 0, 0, 0);
    chk("R6", "take in T2I", req_take, 1);
    step(); st_is("R6 T2I to T2P", 3'd4);
    chk("R6", "addr", bus_addr, 32'hC4);
    drive(0, 0, 0, 1, 0);
    step(); st_is("R4", 3'd3);
    drive(0, 0, 0, 0, 0);
    step(); st_is("R5 T1P to T2", 3'd2);
    drive(0, 0, 0, 1, 0);
    step(); st_is("R7", 3'd0);
    drive(0, 0, 0, 0, 0);
  endtask

  task automatic test_t2i();
    drive(1, 32'hD1, 0, 0, 0);
    step();
    drive(0, 0, 0, 0, 0);
    step(); st_is("R2", 3'd2);
    drive(0, 0, 1, 0, 0);
    step(); st_is("R6 T2 to T2I", 3'd5);
    drive(1, 32'hD2, 0, 1, 0);
    chk("R7", "take at T2I end", req_take, 1);
    step(); st_is("R7 T2I end to T1", 3'd1);
    chk("R7", "addr", bus_addr, 32'hD2);
    drive(0, 0, 0, 1, 0);
    step(); step(); st_is("R7", 3'd0);
    drive(0, 0, 0, 0, 0);
  endtask

  task automatic test_same_cycle();
    drive(1, 32'hE1, 0, 0, 0);
    step();
    drive(1, 32'hE2, 1, 1, 0);
    step(); st_is("R8 T1 ignores both", 3'd2);
    chk("R8", "take", req_take, 1);
    step(); st_is("R8 ready wins", 3'd1);
    chk("R8", "ads_n", ads_n, 0);
    chk("R8", "addr", bus_addr, 32'hE2);
    drive(0, 0, 0, 1, 0);
    step(); step(); st_is("R7", 3'd0);
    drive(0, 0, 0, 0, 0);
  endtask

  task automatic test_hold();
    drive(1, 32'hF1, 0, 0, 1);
    chk("R9", "no take under hold", req_take, 0);
    step(); st_is("R9 idle to hold", 3'd6);
    chk("R9", "hold_ack", hold_ack, 1);
    step(); st_is("R9 stays hold", 3'd6);
    drive(1, 32'hF1, 0, 0, 0);
    step(); st_is("R10 hold to idle", 3'd0);
    chk("R10", "hold_ack low", hold_ack, 0);
    step(); st_is("R10 then T1", 3'd1);
    chk("R10", "addr", bus_addr, 32'hF1);
    drive(1, 32'hF2, 1, 0, 0);
    step(); step(); st_is("R3", 3'd4);
    drive(0, 0, 0, 1, 1);
    step(); st_is("R9 no hold after T2P", 3'd3);
    chk("R9", "hold_ack", hold_ack, 0);
    drive(0, 0, 0, 0, 1);
    step(); st_is("R9", 3'd2);
    drive(1, 32'hF3, 0, 1, 1);
    chk("R9", "hold beats request", req_take, 0);
    step(); st_is("R9 T2 end to hold", 3'd6);
    drive(0, 0, 0, 0, 0);
    step(); st_is("R10", 3'd0);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    step(); step();
    rst_n = 1;
    #2;
    test_reset();
    test_nonpipe();
    test_pipe();
    test_t1p_na();
    test_t2i();
    test_same_cycle();
    test_hold();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule